// File: doc/BRIEF.md
# Grayscale PWM Blank and Scan Sequencer

This block produces the timing for a chain of shift-register PWM LED drivers on a display that multiplexes two columns. A prescaled tick source drives a grayscale clock output and a center-aligned up/down counter. The blanking pulse is decoded from that counter. Once every configurable number of blank periods the block swaps columns. It pulses a one-cycle latch strobe, flips the column-select output and picks the buffer bank for the following column. One cycle later it asks an external serial streamer to send that bank.

The number of blank periods between swaps follows from the grayscale frequency, the counter top and the wanted scan rate, using integer division. The whole swap happens inside the window where blanking is high. The streamer reports completion through a done input. If a new start falls due while the previous transfer is still open, a sticky overrun flag is raised and the start is issued anyway.

Top module: `gs_blank_scan_seq`

## Requirements
- R1: After a synchronous active-low reset the outputs are as follows: `gsclk`=0, `blank`=1, `xlat`=0, `scan`=1 (column 0), `bank_sel`=0, `xfer_start`=0 and `overrun`=0. The counter is at 0 and counting up.
- R2: A tick occurs once every 2·PRE_DIV enabled cycles, where PRE_DIV = SYS_HZ/(GS_HZ·4). The first tick falls on enabled cycle 2·PRE_DIV. `gsclk` toggles on every tick, so its period is two ticks.
- R3: Each tick moves the counter one step. It climbs from 0 to TOP = GS_COUNTS + BLANK_PAD and then falls back to 0, repeating with a period of 2·TOP ticks.
- R4: `blank` is 1 exactly while the counter is below BLANK_PAD.
- R5: An event is the tick that moves the counter from BLANK_PAD down to BLANK_PAD−1. The tick that moves it up to BLANK_PAD is not an event and starts no swap.
- R6: On every (LIMIT+1)-th event, with LIMIT = max(0, ((GS_HZ/TOP)/SCAN_HZ)/2 − 1), `xlat` is 1 for exactly one cycle. That cycle is the one following the event edge, and `blank` is 1 during it.
- R7: `scan` changes only in the cycle where `xlat` is 1, and it inverts there. `scan`=1 means column 0 and `scan`=0 means column 1.
- R8: `bank_sel` is updated in the `xlat` cycle. It becomes 1 when the new column is 0 and 0 when the new column is 1.
- R9: `xfer_start` is a one-cycle pulse in the cycle right after the `xlat` cycle, with `blank` still 1.
- R10: A transfer is open from the edge that issues `xfer_start` until an edge that samples `xfer_done`=1. `overrun` becomes 1 when a start is issued while a transfer is open and `xfer_done` is 0 at that edge. It then stays 1 until reset.
- R11: While `enable` is 0, no tick occurs. `gsclk`, `blank`, the counter and the swap state all hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Lets the prescaler run |
| xfer_done | input | 1 | Streamer finished the last transfer |
| gsclk | output | 1 | Grayscale clock to the drivers |
| blank | output | 1 | Blanking pulse |
| xlat | output | 1 | One-cycle latch strobe |
| scan | output | 1 | Column select, 1 = column 0 |
| bank_sel | output | 1 | Buffer bank to stream next |
| xfer_start | output | 1 | One-cycle request to the streamer |
| overrun | output | 1 | Sticky: start issued while busy |

## Verification
The assertions check a set of local rules on every cycle:
- the counter stays in range and turns only at its ends;
- `xlat` lasts one cycle, follows an event and falls inside blanking;
- `scan` and `bank_sel` move only with `xlat`;
- `xfer_start` follows `xlat`;
- `overrun` never clears on its own.

Other properties depend on counting over long stretches, and only the bench's reference model compares them cycle by cycle against the ports. These are:
- the exact tick spacing and counter phase;
- the number of events between swaps;
- the fact that up-count matches are ignored;
- the freeze under `enable`=0;
- the overrun decision under both prompt and missing done responses.

// File: rtl/gsb_pkg.sv
// Package: shared types and derived-constant helpers for the blank/scan sequencer.
// Assumes integer Hz inputs; every division truncates.
package gsb_pkg;

    typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

    // Prescale divisor ahead of the modulus-2 stage; never below 1.
    function automatic int calc_prediv(input int sys_hz, input int gs_hz);
        int d;
        d = sys_hz / (gs_hz * 4);
        return (d < 1) ? 1 : d;
    endfunction

    // Events counted between column swaps, minus one; never below 0.
    function automatic int calc_limit(input int gs_hz, input int top, input int scan_hz);
        int l;
        l = ((gs_hz / top) / scan_hz) / 2 - 1;
        return (l < 0) ? 0 : l;
    endfunction

    // Width of a counter that must hold 0..maxval, at least 1 bit.
    function automatic int width_for(input int maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/gsb_tick_gen.sv
// Module: tick source and grayscale clock.
// A divide-by-PRE_DIV counter feeds a modulus-2 stage. One tick is emitted
// per full pass of both stages, and gsclk toggles on every tick.
// Assumes PRE_DIV >= 1. Nothing advances while enable is low.
module gsb_tick_gen #(
    parameter int PRE_DIV = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick,
    output logic gsclk
);
    import gsb_pkg::*;

    localparam int PW = width_for(PRE_DIV - 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] pre_cnt;
    logic          half;

    // Tick when both stages are at their last count.
    assign tick = enable && (pre_cnt == PRE_LAST) && half;

    // Prescaler and modulus-2 stage advance on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            half    <= 1'b0;
        end else if (enable) begin
            if (pre_cnt == PRE_LAST) begin
                pre_cnt <= '0;
                half    <= ~half;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    // Grayscale clock toggles on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) gsclk <= 1'b0;
        else if (tick) gsclk <= ~gsclk;
    end

    a_r11_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(gsclk));
    a_r2_gsclk_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(gsclk));

endmodule

// File: rtl/gsb_tri_counter.sv
// Module: center-aligned blank counter.
// Counts 0 up to TOP and back down to 0, one step per tick. blank is high
// below PAD. An event pulse is registered on the tick that leaves PAD
// while counting down; the matching up-count crossing makes no event.
// Assumes 1 <= PAD <= TOP.
module gsb_tri_counter #(
    parameter int TOP = 306,
    parameter int PAD = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic blank,
    output logic evt
);
    import gsb_pkg::*;

    localparam int CW = width_for(TOP);
    localparam logic [CW-1:0] TOP_V = CW'(TOP);
    localparam logic [CW-1:0] PAD_V = CW'(PAD);
    localparam logic [CW-1:0] ONE_V = CW'(1);

    logic [CW-1:0] cnt;
    dir_e          dir;

    assign blank = (cnt < PAD_V);

    // Step the counter and turn it around at the ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (tick) begin
            if (dir == DIR_UP) begin
                cnt <= cnt + 1'b1;
                if (cnt == TOP_V - ONE_V) dir <= DIR_DOWN;
            end else begin
                cnt <= cnt - 1'b1;
                if (cnt == ONE_V) dir <= DIR_UP;
            end
        end
    end

    // Register the down-count compare match.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= tick && (dir == DIR_DOWN) && (cnt == PAD_V);
    end

    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP_V);
    a_r3_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dir) == DIR_UP && dir == DIR_DOWN) |-> cnt == TOP_V);
    a_r3_turn_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dir) == DIR_DOWN && dir == DIR_UP) |-> cnt == '0);
    a_r5_event_opens_blank: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $rose(blank));

endmodule

// File: rtl/gsb_swap_ctrl.sv
// Module: column swap controller.
// Counts events. On the (LIMIT+1)-th event it pulses xlat, inverts the
// column and picks the next bank; a cycle later it requests the transfer.
// It tracks whether the streamer is busy and keeps a sticky overrun flag.
// Assumes evt is a one-cycle pulse spaced more than two cycles apart.
module gsb_swap_ctrl #(
    parameter int LIMIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic xfer_done,
    output logic xlat,
    output logic scan,
    output logic bank_sel,
    output logic xfer_start,
    output logic overrun
);
    import gsb_pkg::*;

    localparam int BW = width_for(LIMIT);
    localparam logic [BW-1:0] LIM_V = BW'(LIMIT);

    logic [BW-1:0] bcnt;
    logic          col;    // 0 = column 0, 1 = column 1
    logic          busy;

    assign scan = ~col;

    // Count events and perform the latch/toggle/bank step at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt     <= '0;
            col      <= 1'b0;
            bank_sel <= 1'b0;
            xlat     <= 1'b0;
        end else begin
            xlat <= 1'b0;
            if (evt) begin
                if (bcnt == LIM_V) begin
                    bcnt     <= '0;
                    xlat     <= 1'b1;
                    col      <= ~col;
                    bank_sel <= col;   // new column 0 -> bank 1, new column 1 -> bank 0
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

    // Issue the transfer request one cycle after the latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_start <= 1'b0;
        else        xfer_start <= xlat;
    end

    // Track the open transfer and flag a start that lands on a busy streamer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            overrun <= 1'b0;
        end else if (xlat) begin
            busy <= 1'b1;
            if (busy && !xfer_done) overrun <= 1'b1;
        end else if (xfer_done) begin
            busy <= 1'b0;
        end
    end

    a_r6_xlat_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        xlat |=> !xlat);
    a_r6_xlat_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        xlat |-> $past(evt));
    a_r7_scan_only_with_xlat: assert property (@(posedge clk) disable iff (!rst_n)
        (scan != $past(scan)) |-> xlat);
    a_r7_scan_flips_on_xlat: assert property (@(posedge clk) disable iff (!rst_n)
        xlat |-> (scan != $past(scan)));
    a_r8_bank_only_with_xlat: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel != $past(bank_sel)) |-> xlat);
    a_r9_start_after_xlat: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> $past(xlat));
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overrun) |-> overrun);

endmodule

// File: rtl/gs_blank_scan_seq.sv
// Module: top of the grayscale blank and scan sequencer.
// It wires the tick source, the center-aligned blank counter and the column
// swap controller together, and derives the divisor, top and swap limit
// from the frequency parameters.
// Assumes SYS_HZ >= 4*GS_HZ and 1 <= BLANK_PAD.
module gs_blank_scan_seq #(
    parameter int SYS_HZ    = 84_000_000,
    parameter int GS_HZ     = 1_000_000,
    parameter int GS_COUNTS = 256,
    parameter int BLANK_PAD = 50,
    parameter int SCAN_HZ   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic xfer_done,
    output logic gsclk,
    output logic blank,
    output logic xlat,
    output logic scan,
    output logic bank_sel,
    output logic xfer_start,
    output logic overrun
);
    import gsb_pkg::*;

    localparam int PRE_DIV = calc_prediv(SYS_HZ, GS_HZ);
    localparam int TOP     = GS_COUNTS + BLANK_PAD;
    localparam int LIMIT   = calc_limit(GS_HZ, TOP, SCAN_HZ);

    logic tick;
    logic evt;

    gsb_tick_gen #(.PRE_DIV(PRE_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .gsclk(gsclk)
    );

    gsb_tri_counter #(.TOP(TOP), .PAD(BLANK_PAD)) i_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .blank(blank), .evt(evt)
    );

    gsb_swap_ctrl #(.LIMIT(LIMIT)) i_swap (
        .clk(clk), .rst_n(rst_n), .evt(evt), .xfer_done(xfer_done),
        .xlat(xlat), .scan(scan), .bank_sel(bank_sel),
        .xfer_start(xfer_start), .overrun(overrun)
    );

    a_r6_latch_inside_blank: assert property (@(posedge clk) disable iff (!rst_n)
        xlat |-> blank);
    a_r9_start_inside_blank: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> blank);

endmodule

// File: tb/test_gs_blank_scan_seq.sv
// Bench: a behavioural reference model built on integer counts is compared
// with every output at each falling edge.
module test_gs_blank_scan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SYS_HZ = 8000, GS_HZ = 1000, GS_COUNTS = 8, PAD = 3, SCAN_HZ = 15;
    localparam int P   = SYS_HZ / (GS_HZ * 4);                  // 2
    localparam int TOP = GS_COUNTS + PAD;                       // 11
    localparam int L   = ((GS_HZ / TOP) / SCAN_HZ) / 2 - 1;     // 2

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, xfer_done = 1'b0;
    logic gsclk, blank, xlat, scan, bank_sel, xfer_start, overrun;

    int n_run = 0, n_fail = 0;
    int e, n, m, col, bank, busy, ov, sw_d1, evt_d, exp_x, exp_s;
    int xl_seen, xl_exp;
    bit auto_done = 1'b1;
    int done_cd = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    gs_blank_scan_seq #(.SYS_HZ(SYS_HZ), .GS_HZ(GS_HZ), .GS_COUNTS(GS_COUNTS),
                        .BLANK_PAD(PAD), .SCAN_HZ(SCAN_HZ)) i_gs_blank_scan_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .xfer_done(xfer_done),
        .gsclk(gsclk), .blank(blank), .xlat(xlat), .scan(scan), .bank_sel(bank_sel),
        .xfer_start(xfer_start), .overrun(overrun));

    function automatic int tri_cnt(input int ticks);
        int p;
        p = ticks % (2 * TOP);
        return (p <= TOP) ? p : 2 * TOP - p;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            e = 0; n = 0; m = 0; col = 0; bank = 0; busy = 0; ov = 0;
            sw_d1 = 0; evt_d = 0; exp_x = 0; exp_s = 0;
        end else begin
            exp_s = sw_d1; sw_d1 = 0;
            if (exp_s == 1) begin
                if (busy == 1 && !xfer_done) ov = 1;
                busy = 1;
            end else if (xfer_done) busy = 0;
            exp_x = 0;
            if (evt_d == 1) begin
                m++;
                if (m % (L + 1) == 0) begin
                    exp_x = 1; col = 1 - col; bank = (col == 0) ? 1 : 0; sw_d1 = 1; xl_exp++;
                end
            end
            evt_d = 0;
            if (enable) begin
                if ((e + 1) % (2 * P) == 0) begin
                    n++;
                    if (n % (2 * TOP) == 2 * TOP - PAD + 1) evt_d = 1;
                end
                e++;
            end
        end
    end

    // Compare at the falling edge; drive the streamer's done response.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 gsclk", gsclk, n % 2);
            chk("R3/R4 blank", blank, (tri_cnt(n) < PAD) ? 1 : 0);
            chk("R5/R6 xlat", xlat, exp_x);
            chk("R7 scan", scan, (col == 0) ? 1 : 0);
            chk("R8 bank_sel", bank_sel, bank);
            chk("R9 xfer_start", xfer_start, exp_s);
            chk("R10 overrun", overrun, ov);
            if (xlat) xl_seen++;
        end
        xfer_done <= 1'b0;
        if (done_cd == 0) xfer_done <= 1'b1;
        if (done_cd >= 0) done_cd--;
        if (xfer_start && auto_done) done_cd = 15;
    end

    task automatic cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        int g_hold, b_hold;
        xl_seen = 0; xl_exp = 0;
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 gsclk", gsclk, 0); chk("R1 blank", blank, 1); chk("R1 xlat", xlat, 0);
        chk("R1 scan", scan, 1); chk("R1 bank_sel", bank_sel, 0);
        chk("R1 xfer_start", xfer_start, 0); chk("R1 overrun", overrun, 0);
        cycles(20);
        // R11: still disabled, nothing moved
        chk("R11 gsclk idle", gsclk, 0);
        chk("R11 blank idle", blank, 1);
        enable = 1'b1;
        cycles(1200);
        // R5: only down-count matches lead to swaps
        chk("R5 swap count", xl_seen, xl_exp);
        chk("R5 swaps happened", (xl_seen >= 3) ? 1 : 0, 1);
        // R11: freeze mid-run
        enable = 1'b0;
        @(negedge clk);
        g_hold = gsclk; b_hold = blank;
        cycles(150);
        chk("R11 gsclk frozen", gsclk, g_hold);
        chk("R11 blank frozen", blank, b_hold);
        enable = 1'b1;
        // R10: stop answering done, so overrun must rise
        auto_done = 1'b0;
        cycles(900);
        chk("R10 overrun raised", overrun, 1);
        auto_done = 1'b1;
        cycles(600);
        chk("R10 overrun sticky", overrun, 1);
        // R1: reset mid-run clears state
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 overrun cleared", overrun, 0);
        chk("R1 scan after reset", scan, 1);
        cycles(1000);
        chk("R5 swap count total", xl_seen, xl_exp);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule